// File: doc/BRIEF.md
# Three-Timer Unit with Prescaler

This block holds three timers sharing one register interface. Timers 0 and 1 each have an external input and an output pin. Each counts from 0 up to a compare value and then wraps to 0. With alternate mode set they swap between two compare values, A and B, on every wrap. This shapes a two-phase output waveform. With alternate mode clear they use only compare A, and the pin drops low for one clock at each wrap. Timer 2 has no pin and only one compare value. Its wrap events can serve as the count clock for timers 0 and 1, so it works as a programmable prescaler.

Software uses one address per register. The address has two bits for the timer (0, 1, 2; index 3 reads as zero) and two bits for the register: 0 = control, 1 = count, 2 = compare A, 3 = compare B. The run bit of a control word is protected: it changes only when the write also sets a guard bit. The guard bit itself is never stored. Any timer can request an interrupt on its wrap. A timer can run continuously or stop itself after one full cycle.

Top module: `tmr_unit`

## Requirements
- R1: After reset every control, count and compare register reads 0, both output pins are high and `irq_o` is low.
- R2: Control word layout is: bit 15 run, bit 14 guard, bit 13 interrupt enable, bit 12 active-compare flag (1 = B, read only), bit 3 prescale source, bit 2 external source, bit 1 alternate, bit 0 continuous; other bits read 0. The run bit takes the written value only when bit 14 is 1 in the same write. Bit 14 always reads 0.
- R3: With neither source bit set, a running timer counts one step per tick of a free-running divider. The divider ticks once every 4 clocks, starting from reset, and timer 2 always counts on it.
- R4: On a counting step where the count equals the active compare value, the count becomes 0 (a wrap); otherwise it increments.
- R5: With alternate set, each wrap toggles the active compare between A and B. The pin is high while A is active and low while B is active.
- R6: With alternate clear, the pin is high except for the single clock after a wrap, when it is low.
- R7: With continuous clear, the run bit clears at the final wrap. That is the wrap on A when alternate is clear, or the wrap on B when alternate is set.
- R8: With the external source set, the timer steps once per 4 rising edges of its input. The input passes through two synchronising flops before edge detection, and divider ticks are ignored.
- R9: With the prescale source set (external clear), timers 0 and 1 step on each timer 2 wrap. The external source takes precedence when both are set.
- R10: `irq_o` is high for exactly the clock after any wrap of a timer whose interrupt enable is set.
- R11: Timer 2 stores no prescale, external or alternate bits (they read 0), and its compare B reads 0.
- R12: A count write loads the count. A control write resets the active compare to A and sets the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address: [3:2] timer, [1:0] register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| ext_i | input | 2 | External inputs of timers 0 and 1 (asynchronous) |
| tout_o | output | 2 | Output pins of timers 0 and 1 |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The one-clock output pulse and the `irq_o` checks assume no timer can wrap on two consecutive clocks. That holds because divider ticks are 4 clocks apart. Timer 2 wraps occur only on such ticks, and an external tick needs four synchronised edges. The bench toggles each external input no faster than every three clocks, so edges are well separated. The count-step assertion assumes the only jumps other than +1 or to 0 come from register writes. The bench writes count values only after stopping a timer or while checking a load.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 4;

    localparam int BIT_RUN   = 15;
    localparam int BIT_GUARD = 14;
    localparam int BIT_IE    = 13;
    localparam int BIT_BSEL  = 12;
    localparam int BIT_PRE   = 3;
    localparam int BIT_EXT   = 2;
    localparam int BIT_ALT   = 1;
    localparam int BIT_CONT  = 0;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMPA  = 2'd2,
        REG_CMPB  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic ie;
        logic pre;
        logic ext;
        logic alt;
        logic cont;
    } tmr_ctrl_t;

    function automatic logic [BUS_W-1:0] ctrl_pack(tmr_ctrl_t c, logic bsel);
        logic [BUS_W-1:0] w;
        w            = '0;
        w[BIT_RUN]   = c.run;
        w[BIT_IE]    = c.ie;
        w[BIT_BSEL]  = bsel;
        w[BIT_PRE]   = c.pre;
        w[BIT_EXT]   = c.ext;
        w[BIT_ALT]   = c.alt;
        w[BIT_CONT]  = c.cont;
        return w;
    endfunction

    function automatic tmr_ctrl_t ctrl_unpack(logic [BUS_W-1:0] w, logic run_keep, logic has_src);
        tmr_ctrl_t c;
        c.run  = w[BIT_GUARD] ? w[BIT_RUN] : run_keep;
        c.ie   = w[BIT_IE];
        c.pre  = has_src & w[BIT_PRE];
        c.ext  = has_src & w[BIT_EXT];
        c.alt  = has_src & w[BIT_ALT];
        c.cont = w[BIT_CONT];
        return c;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] cnt_q;

    assign tick_o = (cnt_q == PW'(DIV - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic tick_o
);
    localparam int EW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [2:0]    shr_q;
    logic [EW-1:0] ecnt_q;
    logic          rise_w;

    assign rise_w = shr_q[1] & ~shr_q[2];
    assign tick_o = rise_w && (ecnt_q == EW'(DIV - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shr_q  <= '0;
            ecnt_q <= '0;
        end else begin
            shr_q <= {shr_q[1:0], pin_i};
            if (rise_w) ecnt_q <= tick_o ? '0 : ecnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_ALT = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  reg_sel_e         reg_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             tick_int_i,
    input  logic             tick_pre_i,
    input  logic             tick_ext_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o,
    output logic             tout_o,
    output logic             run_o,
    output logic             ie_o,
    output logic             alt_o,
    output logic             bsel_o
);
    tmr_ctrl_t        ctrl_q, ctrl_d;
    logic [CNT_W-1:0] cnt_q, cmpa_q, cmpb_w, active_w;
    logic             bsel_q, tout_q, tick_w, final_w;

    assign tick_w   = ctrl_q.ext ? tick_ext_i : (ctrl_q.pre ? tick_pre_i : tick_int_i);
    assign active_w = bsel_q ? cmpb_w : cmpa_q;
    assign hit_o    = ctrl_q.run && tick_w && (cnt_q == active_w);
    assign final_w  = ctrl_q.alt ? bsel_q : 1'b1;

    always_comb begin
        ctrl_d = ctrl_q;
        if (hit_o && final_w && !ctrl_q.cont) ctrl_d.run = 1'b0;
        if (we_i && reg_i == REG_CTRL)
            ctrl_d = ctrl_unpack(wdata_i, ctrl_d.run, HAS_ALT);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            cmpa_q <= '0;
            bsel_q <= 1'b0;
            tout_q <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
            if (hit_o) begin
                cnt_q <= '0;
                if (ctrl_q.alt) bsel_q <= ~bsel_q;
            end else if (ctrl_q.run && tick_w) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (hit_o)            tout_q <= ctrl_q.alt ? bsel_q : 1'b0;
            else if (!ctrl_q.alt) tout_q <= 1'b1;
            if (we_i) begin
                case (reg_i)
                    REG_CTRL: begin
                        bsel_q <= 1'b0;
                        tout_q <= 1'b1;
                    end
                    REG_COUNT: cnt_q  <= wdata_i[CNT_W-1:0];
                    REG_CMPA:  cmpa_q <= wdata_i[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    generate
        if (HAS_ALT) begin : g_cmpb
            logic [CNT_W-1:0] cmpb_q;
            always_ff @(posedge clk_i) begin
                if (rst_i)                            cmpb_q <= '0;
                else if (we_i && reg_i == REG_CMPB)   cmpb_q <= wdata_i[CNT_W-1:0];
            end
            assign cmpb_w = cmpb_q;
        end else begin : g_no_cmpb
            assign cmpb_w = '0;
        end
    endgenerate

    always_comb begin
        case (reg_i)
            REG_CTRL:  rdata_o = ctrl_pack(ctrl_q, bsel_q);
            REG_COUNT: rdata_o = BUS_W'(cnt_q);
            REG_CMPA:  rdata_o = BUS_W'(cmpa_q);
            default:   rdata_o = BUS_W'(cmpb_w);
        endcase
    end

    assign cnt_o  = cnt_q;
    assign tout_o = tout_q;
    assign run_o  = ctrl_q.run;
    assign ie_o   = ctrl_q.ie;
    assign alt_o  = ctrl_q.alt;
    assign bsel_o = bsel_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4,
    parameter int EDGE_DIV = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [1:0]        ext_i,
    output logic [1:0]        tout_o,
    output logic              irq_o
);
    localparam int NPIN = 2;
    localparam int NT   = NPIN + 1;

    reg_sel_e         reg_w;
    logic [1:0]       tsel_w;
    logic             tick_int_w;
    logic [BUS_W-1:0] rd_w [NT];
    logic [CNT_W-1:0] cnt_w [NT];
    logic [NPIN-1:0]  hitp_w, toutp_w, runp_w, iep_w, altp_w, bselp_w;
    logic             hit2_w, tout2_w, run2_w, ie2_w, alt2_w, bsel2_w;
    logic [NT-1:0]    hit_w, tout_w, run_w, ie_w, alt_w, bsel_w;
    logic             irq_q;

    assign reg_w  = reg_sel_e'(addr_i[1:0]);
    assign tsel_w = addr_i[3:2];

    tmr_prescale #(.DIV(PRESCALE)) u_pre (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick_int_w)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NPIN; gi++) begin : g_pin
            logic tick_ext_w;
            tmr_sync_edge #(.DIV(EDGE_DIV)) u_sync (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .pin_i (ext_i[gi]),
                .tick_o(tick_ext_w)
            );
            tmr_core #(.CNT_W(CNT_W), .HAS_ALT(1'b1)) u_core (
                .clk_i     (clk_i),
                .rst_i     (rst_i),
                .we_i      (we_i && tsel_w == 2'(gi)),
                .reg_i     (reg_w),
                .wdata_i   (wdata_i),
                .tick_int_i(tick_int_w),
                .tick_pre_i(hit2_w),
                .tick_ext_i(tick_ext_w),
                .rdata_o   (rd_w[gi]),
                .cnt_o     (cnt_w[gi]),
                .hit_o     (hitp_w[gi]),
                .tout_o    (toutp_w[gi]),
                .run_o     (runp_w[gi]),
                .ie_o      (iep_w[gi]),
                .alt_o     (altp_w[gi]),
                .bsel_o    (bselp_w[gi])
            );
        end
    endgenerate

    tmr_core #(.CNT_W(CNT_W), .HAS_ALT(1'b0)) u_core2 (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (we_i && tsel_w == 2'(NPIN)),
        .reg_i     (reg_w),
        .wdata_i   (wdata_i),
        .tick_int_i(tick_int_w),
        .tick_pre_i(1'b0),
        .tick_ext_i(1'b0),
        .rdata_o   (rd_w[NPIN]),
        .cnt_o     (cnt_w[NPIN]),
        .hit_o     (hit2_w),
        .tout_o    (tout2_w),
        .run_o     (run2_w),
        .ie_o      (ie2_w),
        .alt_o     (alt2_w),
        .bsel_o    (bsel2_w)
    );

    assign hit_w  = {hit2_w,  hitp_w};
    assign tout_w = {tout2_w, toutp_w};
    assign run_w  = {run2_w,  runp_w};
    assign ie_w   = {ie2_w,   iep_w};
    assign alt_w  = {alt2_w,  altp_w};
    assign bsel_w = {bsel2_w, bselp_w};

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= 1'b0;
        else       irq_q <= |(hit_w & ie_w);
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NT; i++)
            if (tsel_w == 2'(i)) rdata_o = rd_w[i];
    end

    assign tout_o = toutp_w;
    assign irq_o  = irq_q;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             we_i,
    input logic [3:0]       addr_i,
    input logic [15:0]      wdata_i,
    input logic [CNT_W-1:0] cnt0_i,
    input logic [2:0]       hit_i,
    input logic [2:0]       ie_i,
    input logic [2:0]       run_i,
    input logic [2:0]       alt_i,
    input logic [2:0]       bsel_i,
    input logic [2:0]       tout_i,
    input logic             irq_i
);
    // R10: every request follows an enabled wrap, and every enabled wrap raises one
    assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_i |-> $past(|(hit_i & ie_i)));
    assert_irq_follow_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(hit_i & ie_i)) |=> irq_i);

    // R2: a control write without the guard bit never starts timer 0
    assert_guard_run_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && addr_i == 4'h0 && !wdata_i[14] && !run_i[0]) |=> !run_i[0]);

    // R4: without a write the count only holds, steps by one, or wraps to zero
    assert_count_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(we_i) |-> (cnt0_i == $past(cnt0_i) ||
                          cnt0_i == $past(cnt0_i) + CNT_W'(1) ||
                          cnt0_i == '0));

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_pin
            // R5: in alternate mode the pin reports the active compare
            assert_alt_level_R5: assert property (@(posedge clk_i) disable iff (rst_i)
                alt_i[gi] |-> (tout_i[gi] == !bsel_i[gi]));
            // R6: in single-compare mode a low pin lasts one clock
            assert_low_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
                (!alt_i[gi] && !tout_i[gi]) |=> tout_i[gi]);
        end
    endgenerate
endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .cnt0_i (cnt_w[0]),
    .hit_i  (hit_w),
    .ie_i   (ie_w),
    .run_i  (run_w),
    .alt_i  (alt_w),
    .bsel_i (bsel_w),
    .tout_i (tout_w),
    .irq_i  (irq_o)
);

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [1:0]  ext = 2'b00;
    logic [1:0]  tout;
    logic        irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_unit dut_i (
        .clk_i(clk), .rst_i(rst), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .ext_i(ext), .tout_o(tout), .irq_o(irq)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string phase = "R1";

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    bit m_run[3], m_ie[3], m_pre[3], m_ext[3], m_alt[3], m_cont[3], m_bsel[3], m_tout[3];
    int m_cnt[3], m_ca[3], m_cb[3];
    int m_ps;
    bit m_s1[2], m_s2[2], m_s3[2];
    int m_ec[2];
    bit m_irq;

    function automatic int mread(logic [3:0] a);
        int t = a[3:2];
        if (t == 3) return 0;
        case (a[1:0])
            2'd0: return (int'(m_run[t]) << 15) | (int'(m_ie[t]) << 13) | (int'(m_bsel[t]) << 12) |
                         (int'(m_pre[t]) << 3) | (int'(m_ext[t]) << 2) | (int'(m_alt[t]) << 1) |
                         int'(m_cont[t]);
            2'd1: return m_cnt[t];
            2'd2: return m_ca[t];
            default: return (t < 2) ? m_cb[t] : 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ti; bit te[2]; bit hh[3]; bit tk[3]; bit eg; bit fin; bit irqn; int act; int t;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_run[i] = 0; m_ie[i] = 0; m_pre[i] = 0; m_ext[i] = 0; m_alt[i] = 0;
                m_cont[i] = 0; m_bsel[i] = 0; m_tout[i] = 1; m_cnt[i] = 0; m_ca[i] = 0; m_cb[i] = 0;
            end
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_ec[i] = 0;
            end
            m_ps = 0; m_irq = 0;
        end else begin
            ti = (m_ps == 3);
            m_ps = (m_ps + 1) % 4;
            for (int i = 0; i < 2; i++) begin
                eg = m_s2[i] && !m_s3[i];
                te[i] = eg && (m_ec[i] == 3);
                if (eg) m_ec[i] = (m_ec[i] + 1) % 4;
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = ext[i];
            end
            tk[2] = ti;
            hh[2] = m_run[2] && ti && (m_cnt[2] == m_ca[2]);
            for (int i = 0; i < 2; i++) begin
                tk[i] = m_ext[i] ? te[i] : (m_pre[i] ? hh[2] : ti);
                act = m_bsel[i] ? m_cb[i] : m_ca[i];
                hh[i] = m_run[i] && tk[i] && (m_cnt[i] == act);
            end
            irqn = 0;
            for (int i = 0; i < 3; i++) if (hh[i] && m_ie[i]) irqn = 1;
            for (int i = 0; i < 3; i++) begin
                if (hh[i]) begin
                    fin = m_alt[i] ? m_bsel[i] : 1'b1;
                    m_tout[i] = m_alt[i] ? m_bsel[i] : 1'b0;
                    m_cnt[i] = 0;
                    if (m_alt[i]) m_bsel[i] = !m_bsel[i];
                    if (fin && !m_cont[i]) m_run[i] = 0;
                end else begin
                    if (m_run[i] && tk[i]) m_cnt[i] = (m_cnt[i] + 1) & 16'hFFFF;
                    if (!m_alt[i]) m_tout[i] = 1;
                end
            end
            if (we) begin
                t = addr[3:2];
                if (t < 3) begin
                    case (addr[1:0])
                        2'd0: begin
                            m_ie[t] = wdata[13];
                            m_cont[t] = wdata[0];
                            m_pre[t] = (t < 2) && wdata[3];
                            m_ext[t] = (t < 2) && wdata[2];
                            m_alt[t] = (t < 2) && wdata[1];
                            if (wdata[14]) m_run[t] = wdata[15];
                            m_bsel[t] = 0;
                            m_tout[t] = 1;
                        end
                        2'd1: m_cnt[t] = wdata;
                        2'd2: m_ca[t] = wdata;
                        default: if (t < 2) m_cb[t] = wdata;
                    endcase
                end
            end
            m_irq = irqn;
        end
    end

    // Clock-by-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check({phase, " pin0"}, int'(tout[0]), int'(m_tout[0]));
            check({phase, " pin1"}, int'(tout[1]), int'(m_tout[1]));
            check({phase, " irq"}, int'(irq), int'(m_irq));
            check({phase, " rdata"}, int'(rdata), mread(addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [3:0] ra(int t, int r);
        return {2'(t), 2'(r)};
    endfunction

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #Q;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(posedge clk); #Q;
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #Q;
        we = 1'b0;
    endtask

    task automatic rd_check(string req, logic [3:0] a, int exp);
        @(posedge clk); #Q;
        addr = a;
        @(negedge clk);
        check(req, int'(rdata), exp);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;

        // R1: reset state
        phase = "R1";
        for (int a = 0; a < 16; a++) rd_check("R1", 4'(a), 0);
        @(negedge clk);
        check("R1 pins", int'(tout), 3);
        check("R1 irq", int'(irq), 0);

        // R2: guarded run bit
        phase = "R2";
        wr(ra(0, 2), 16'd5);
        wr(ra(0, 0), 16'h8001);
        rd_check("R2 unguarded", ra(0, 0), 16'h0001);
        wr(ra(0, 0), 16'hC001);
        rd_check("R2 guarded", ra(0, 0), 16'h8001);

        // R3 / R4: divided counting and wrap
        phase = "R3";
        addr = ra(0, 1);
        idle(20);
        phase = "R4";
        idle(40);

        // R12: count load, control write resets pin
        phase = "R12";
        wr(ra(0, 0), 16'h4001);
        wr(ra(0, 1), 16'h1234);
        rd_check("R12 load", ra(0, 1), 16'h1234);
        wr(ra(0, 1), 16'h0000);

        // R6 / R10: single compare pulses with interrupts
        phase = "R6";
        wr(ra(0, 2), 16'd2);
        wr(ra(0, 0), 16'hE001);
        addr = ra(0, 1);
        idle(40);
        phase = "R10";
        idle(24);

        // R5: alternate compare on timer 1
        phase = "R5";
        wr(ra(1, 2), 16'd2);
        wr(ra(1, 3), 16'd4);
        wr(ra(1, 0), 16'hC003);
        addr = ra(1, 0);
        idle(70);

        // R7: single-shot, both modes
        phase = "R7";
        wr(ra(0, 0), 16'h4000);
        wr(ra(0, 1), 16'd0);
        wr(ra(0, 2), 16'd3);
        wr(ra(0, 0), 16'hC000);
        idle(40);
        rd_check("R7 stop A", ra(0, 0), 16'h0000);
        rd_check("R7 count", ra(0, 1), 0);
        wr(ra(1, 0), 16'h4000);
        wr(ra(1, 1), 16'd0);
        wr(ra(1, 0), 16'hC002);
        idle(80);
        rd_check("R7 stop B", ra(1, 0), 16'h0002);
        rd_check("R7 count B", ra(1, 1), 0);

        // R8: external source on timer 1
        phase = "R8";
        wr(ra(1, 0), 16'h4000);
        wr(ra(1, 1), 16'd0);
        wr(ra(1, 2), 16'd3);
        wr(ra(1, 0), 16'hC005);
        idle(20);
        rd_check("R8 no divider ticks", ra(1, 1), 0);
        for (int k = 0; k < 40; k++) begin
            ext[1] = ~ext[1];
            idle(3);
        end
        idle(6);

        // R9: timer 2 as prescaler, external wins over prescale
        phase = "R9";
        wr(ra(2, 2), 16'd1);
        wr(ra(2, 0), 16'hC001);
        wr(ra(0, 0), 16'h4000);
        wr(ra(0, 1), 16'd0);
        wr(ra(0, 2), 16'd100);
        wr(ra(0, 0), 16'hC009);
        addr = ra(0, 1);
        idle(80);
        wr(ra(1, 0), 16'h4000);
        wr(ra(1, 1), 16'd0);
        wr(ra(1, 0), 16'hC00D);
        idle(30);
        rd_check("R9 external precedence", ra(1, 1), 0);

        // R11: timer 2 restrictions
        phase = "R11";
        wr(ra(2, 0), 16'hE00F);
        rd_check("R11 ctrl", ra(2, 0), 16'hA001);
        wr(ra(2, 3), 16'h5555);
        rd_check("R11 cmpB", ra(2, 3), 0);

        idle(4);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule